// File: doc/BRIEF.md
# MDIO Management Register Controller

This block lets a processor reach the management registers of an external Ethernet PHY over the two-wire MDC/MDIO serial interface. Software programs a small set of word registers through a simple write-enable/address/data port. It selects the PHY and the register number, then starts a cycle. A write cycle begins as soon as the 16-bit write value is stored. A read cycle begins on a 0-to-1 transition of the read command bit. When the read finishes, its result can be read back from a status register.

An indicator register shows whether a frame is in progress. It also shows whether read data is still pending. A configuration register selects the MDC clock rate as a fraction of the system clock, can drop the 32-bit preamble, and offers a self-clearing reset of the management logic. Frames use standard management framing. Continuous polling and extended (clause 45) framing are not provided.

Register word indices on `regAddr`: 0 configuration, 1 command, 2 address, 3 write data, 4 read data, 5 indicators.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset, the indicator register (index 5) and the read data register (index 4) read 0, and `mdc` and `mdioOe` are low.
- R2: A write frame is sent MSB first. It consists of 32 ones of preamble, then start 01, opcode 01, the 5-bit PHY address, the 5-bit register number, turnaround 10 and the 16 data bits. Every bit is driven with `mdioOe` high and is stable at each rising edge of `mdc`.
- R3: Writing index 3 (value in bits 15:0) starts a write frame. Indicator bit 0 (busy) is 1 from the clock edge that stores the write. It returns to 0 only after the final falling `mdc` edge, and a full frame gives exactly 64 rising `mdc` edges.
- R4: A 0-to-1 change of command bit 0 (index 1) starts a read frame with opcode 10. `mdioOe` is high for the preamble and the first 14 frame bits, and low for the turnaround and the 16 data bits. Data is sampled MSB first on rising `mdc` and then appears in bits 15:0 of index 4.
- R5: Indicator bit 2 (not-valid) is 1 from the start of a read until the read data is stored, and then returns to 0.
- R6: Writing 1 to command bit 0 while it already holds 1 starts no frame. A read starts again only after 0 and then 1 have been written.
- R7: A write-data store or a read request that arrives while busy is 1 is discarded. It starts no frame, and the discarded write value does not replace the stored one.
- R8: With configuration bit 4 set, the preamble is omitted and a frame has 32 rising `mdc` edges.
- R9: Configuration bits 2:0 choose the `mdc` period in system clocks. Codes 0 through 7 give 4, 4, 6, 8, 10, 14, 20 and 28, and each `mdc` half period is half of that value.
- R10: Writing configuration bit 31 aborts any frame. It clears busy and not-valid, returns `mdc` and `mdioOe` low, and leaves bit 31 reading 0. The next command then runs a complete frame.
- R11: Command bit 1 (scan request) starts no frame, and indicator bit 1 always reads 0.
- R12: Configuration readback returns only bits 2:0 and 4. Address readback (index 2) returns the PHY address in bits 12:8 and the register number in bits 4:0, and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | 3 | Register word index for read and write |
| regWrData | input | 32 | Register write value |
| regRdData | output | 32 | Register read value for `regAddr` (combinational) |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | Serial data driven toward the PHY |
| mdioOe | output | 1 | Output enable for the MDIO pad |
| mdioIn | input | 1 | Serial data returned from the PHY |

## Verification
Assertions check these properties on every cycle:
- a launch never reaches the serializer while a frame is running;
- an idle write store always raises busy on the next edge;
- a repeated read request with the command bit already set never launches;
- a discarded write leaves the stored value unchanged;
- not-valid only falls on frame completion or a management reset;
- the done pulse always coincides with a falling MDC edge.

Only the bench scenarios can show that the serialized bit sequence, the output-enable pattern and the MDC period match the programmed values. The same holds for correct capture of PHY read data and for the way abort, re-arm and scan requests look on the pins.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int REG_AW = 3;
  localparam int DIV_W  = 3;
  localparam int HALF_W = 4;

  localparam int CFG_NOPRE_BIT = 4;
  localparam int CFG_RESET_BIT = 31;
  localparam int CMD_READ_BIT  = 0;
  localparam int CMD_SCAN_BIT  = 1;
  localparam int IND_BUSY_BIT  = 0;
  localparam int IND_SCAN_BIT  = 1;
  localparam int IND_NV_BIT    = 2;

  typedef enum logic [REG_AW-1:0] {
    RegCfg  = 3'd0,
    RegCmd  = 3'd1,
    RegAdr  = 3'd2,
    RegWdat = 3'd3,
    RegRdat = 3'd4,
    RegInd  = 3'd5
  } regSel_e;

  // strobes from the control module to the serializer
  typedef struct packed {
    logic launch;
    logic isRead;
    logic abort;
  } ctlStrobe_t;

  // MDC half period in system clocks for each divider code
  function automatic logic [HALF_W-1:0] halfPeriod(input logic [DIV_W-1:0] sel);
    case (sel)
      3'd0, 3'd1: halfPeriod = 4'd2;
      3'd2:       halfPeriod = 4'd3;
      3'd3:       halfPeriod = 4'd4;
      3'd4:       halfPeriod = 4'd5;
      3'd5:       halfPeriod = 4'd7;
      3'd6:       halfPeriod = 4'd10;
      default:    halfPeriod = 4'd14;
    endcase
  endfunction

endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int CPU_W   = 32,
  parameter int DATA_W  = 16,
  parameter int FIELD_W = 5,
  parameter int PHY_LSB = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [REG_AW-1:0]    regAddr,
  input  logic [CPU_W-1:0]     regWrData,
  output logic [CPU_W-1:0]     regRdData,
  input  logic                 dpDone,
  input  logic [DATA_W-1:0]    dpRdData,
  output ctlStrobe_t           strobe,
  output logic [FIELD_W-1:0]   phyAdr,
  output logic [FIELD_W-1:0]   regNum,
  output logic [DATA_W-1:0]    wrData,
  output logic [DIV_W-1:0]     divSel,
  output logic                 noPre
);

  logic [DIV_W-1:0]   divSelQ;
  logic               noPreQ;
  logic [1:0]         cmdQ;
  logic [FIELD_W-1:0] phyQ;
  logic [FIELD_W-1:0] regQ;
  logic [DATA_W-1:0]  wrDataQ;
  logic [DATA_W-1:0]  rdDataQ;
  logic               busyQ;
  logic               notValidQ;
  logic               curReadQ;
  ctlStrobe_t         strobeQ;

  logic wrCfg, wrCmd, wrAdr, wrCtl, softRst, startWrite, startRead;

  always_comb begin
    wrCfg      = regWrEn && (regAddr == RegCfg);
    wrCmd      = regWrEn && (regAddr == RegCmd);
    wrAdr      = regWrEn && (regAddr == RegAdr);
    wrCtl      = regWrEn && (regAddr == RegWdat);
    softRst    = wrCfg && regWrData[CFG_RESET_BIT];
    startWrite = wrCtl && !busyQ;
    startRead  = wrCmd && regWrData[CMD_READ_BIT] && !cmdQ[CMD_READ_BIT] && !busyQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divSelQ   <= '0;
      noPreQ    <= 1'b0;
      cmdQ      <= '0;
      phyQ      <= '0;
      regQ      <= '0;
      wrDataQ   <= '0;
      rdDataQ   <= '0;
      busyQ     <= 1'b0;
      notValidQ <= 1'b0;
      curReadQ  <= 1'b0;
      strobeQ   <= '0;
    end else begin
      strobeQ <= '0;
      if (wrCfg) begin
        divSelQ <= regWrData[DIV_W-1:0];
        noPreQ  <= regWrData[CFG_NOPRE_BIT];
      end
      if (wrCmd) cmdQ <= regWrData[1:0];
      if (wrAdr) begin
        phyQ <= regWrData[PHY_LSB +: FIELD_W];
        regQ <= regWrData[FIELD_W-1:0];
      end
      if (softRst) begin
        strobeQ.abort <= 1'b1;
        busyQ         <= 1'b0;
        notValidQ     <= 1'b0;
        curReadQ      <= 1'b0;
      end else if (startWrite) begin
        wrDataQ        <= regWrData[DATA_W-1:0];
        strobeQ.launch <= 1'b1;
        strobeQ.isRead <= 1'b0;
        busyQ          <= 1'b1;
        curReadQ       <= 1'b0;
      end else if (startRead) begin
        strobeQ.launch <= 1'b1;
        strobeQ.isRead <= 1'b1;
        busyQ          <= 1'b1;
        notValidQ      <= 1'b1;
        curReadQ       <= 1'b1;
      end else if (dpDone) begin
        busyQ <= 1'b0;
        if (curReadQ) begin
          rdDataQ   <= dpRdData;
          notValidQ <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    regRdData = '0;
    case (regAddr)
      RegCfg: begin
        regRdData[DIV_W-1:0]     = divSelQ;
        regRdData[CFG_NOPRE_BIT] = noPreQ;
      end
      RegCmd:  regRdData[1:0] = cmdQ;
      RegAdr: begin
        regRdData[PHY_LSB +: FIELD_W] = phyQ;
        regRdData[FIELD_W-1:0]        = regQ;
      end
      RegWdat: regRdData[DATA_W-1:0] = wrDataQ;
      RegRdat: regRdData[DATA_W-1:0] = rdDataQ;
      RegInd: begin
        regRdData[IND_BUSY_BIT] = busyQ;
        regRdData[IND_SCAN_BIT] = 1'b0;
        regRdData[IND_NV_BIT]   = notValidQ;
      end
      default: regRdData = '0;
    endcase
  end

  assign strobe = strobeQ;
  assign phyAdr = phyQ;
  assign regNum = regQ;
  assign wrData = wrDataQ;
  assign divSel = divSelQ;
  assign noPre  = noPreQ;

  // R3: an idle write store raises busy and launches a write on the next edge
  a_r3_write_launch: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtl && !busyQ) |=> (busyQ && strobeQ.launch && !strobeQ.isRead));

  // R6: a repeated read request with the command bit already set never launches
  a_r6_no_rearm: assert property (@(posedge clk) disable iff (!rstN)
    (wrCmd && cmdQ[CMD_READ_BIT] && !busyQ) |=> !strobeQ.launch);

  // R7: a write store while busy leaves the stored value untouched
  a_r7_busy_ignore: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtl && busyQ) |=> $stable(wrDataQ));

  // R5: not-valid only drops on frame completion or management reset
  a_r5_nv_release: assert property (@(posedge clk) disable iff (!rstN)
    $fell(notValidQ) |-> ($past(dpDone) || $past(softRst)));

endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
#(
  parameter int PRE_LEN = 32,
  parameter int DATA_W  = 16,
  parameter int FIELD_W = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strobe,
  input  logic [FIELD_W-1:0] phyAdr,
  input  logic [FIELD_W-1:0] regNum,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [DIV_W-1:0]   divSel,
  input  logic               noPre,
  input  logic               mdioIn,
  output logic               mdc,
  output logic               mdioOut,
  output logic               mdioOe,
  output logic               done,
  output logic [DATA_W-1:0]  rdData
);

  localparam int HDR_LEN   = 4 + 2 * FIELD_W;
  localparam int BODY_LEN  = HDR_LEN + 2 + DATA_W;
  localparam int TOTAL_LEN = PRE_LEN + BODY_LEN;
  localparam int IDX_W     = $clog2(TOTAL_LEN + 1);

  logic               runQ;
  logic               readQ;
  logic               noPreQ;
  logic [HALF_W-1:0]  halfQ;
  logic [HALF_W-1:0]  halfCntQ;
  logic               mdcQ;
  logic [IDX_W-1:0]   bitIdxQ;
  logic [BODY_LEN-1:0] bodyQ;
  logic [DATA_W-1:0]  rdShiftQ;
  logic               doneQ;

  logic [IDX_W-1:0] preOff, bodyPos, lastIdx;
  logic             inPre, halfTick, sampleNow;

  always_comb begin
    preOff    = noPreQ ? '0 : IDX_W'(PRE_LEN);
    lastIdx   = noPreQ ? IDX_W'(BODY_LEN - 1) : IDX_W'(TOTAL_LEN - 1);
    inPre     = bitIdxQ < preOff;
    bodyPos   = bitIdxQ - preOff;
    halfTick  = (halfCntQ == halfQ - 1'b1);
    sampleNow = readQ && !inPre && (bodyPos >= IDX_W'(HDR_LEN + 2));
    mdioOe    = runQ && (!readQ || inPre || (bodyPos < IDX_W'(HDR_LEN)));
    mdioOut   = mdioOe && (inPre || bodyQ[BODY_LEN-1]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runQ     <= 1'b0;
      readQ    <= 1'b0;
      noPreQ   <= 1'b0;
      halfQ    <= '0;
      halfCntQ <= '0;
      mdcQ     <= 1'b0;
      bitIdxQ  <= '0;
      bodyQ    <= '0;
      rdShiftQ <= '0;
      doneQ    <= 1'b0;
    end else if (strobe.abort) begin
      runQ  <= 1'b0;
      mdcQ  <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (strobe.launch) begin
        runQ     <= 1'b1;
        readQ    <= strobe.isRead;
        noPreQ   <= noPre;
        halfQ    <= halfPeriod(divSel);
        halfCntQ <= '0;
        mdcQ     <= 1'b0;
        bitIdxQ  <= '0;
        rdShiftQ <= '0;
        bodyQ    <= {2'b01, (strobe.isRead ? 2'b10 : 2'b01), phyAdr, regNum,
                     (strobe.isRead ? 2'b00 : 2'b10),
                     (strobe.isRead ? DATA_W'(0) : wrData)};
      end else if (runQ) begin
        if (halfTick) begin
          halfCntQ <= '0;
          mdcQ     <= ~mdcQ;
          if (!mdcQ) begin
            if (sampleNow) rdShiftQ <= {rdShiftQ[DATA_W-2:0], mdioIn};
          end else if (bitIdxQ == lastIdx) begin
            runQ  <= 1'b0;
            doneQ <= 1'b1;
          end else begin
            bitIdxQ <= bitIdxQ + 1'b1;
            if (!inPre) bodyQ <= bodyQ << 1;
          end
        end else begin
          halfCntQ <= halfCntQ + 1'b1;
        end
      end
    end
  end

  assign mdc    = mdcQ;
  assign done   = doneQ;
  assign rdData = rdShiftQ;

  // R7: the control never hands over a new frame while one is running
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    strobe.launch |-> !runQ);

  // R10: an abort silences the pins on the next edge
  a_r10_abort_quiet: assert property (@(posedge clk) disable iff (!rstN)
    strobe.abort |=> (!runQ && !mdcQ));

  // R3: frame completion coincides with a falling MDC edge
  a_r3_done_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |-> ($past(mdcQ) && !mdcQ));

endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int CPU_W   = 32,
  parameter int DATA_W  = 16,
  parameter int FIELD_W = 5,
  parameter int PHY_LSB = 8,
  parameter int PRE_LEN = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [CPU_W-1:0]  regWrData,
  output logic [CPU_W-1:0]  regRdData,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  input  logic              mdioIn
);

  ctlStrobe_t         strobe;
  logic [FIELD_W-1:0] phyAdr;
  logic [FIELD_W-1:0] regNum;
  logic [DATA_W-1:0]  wrData;
  logic [DATA_W-1:0]  rdData;
  logic [DIV_W-1:0]   divSel;
  logic               noPre;
  logic               dpDone;

  mdio_ctrl #(
    .CPU_W(CPU_W), .DATA_W(DATA_W), .FIELD_W(FIELD_W), .PHY_LSB(PHY_LSB)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .dpDone(dpDone), .dpRdData(rdData),
    .strobe(strobe), .phyAdr(phyAdr), .regNum(regNum), .wrData(wrData),
    .divSel(divSel), .noPre(noPre)
  );

  mdio_datapath #(
    .PRE_LEN(PRE_LEN), .DATA_W(DATA_W), .FIELD_W(FIELD_W)
  ) i_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .phyAdr(phyAdr), .regNum(regNum), .wrData(wrData),
    .divSel(divSel), .noPre(noPre), .mdioIn(mdioIn),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe),
    .done(dpDone), .rdData(rdData)
  );

endmodule

// File: tb/test_mdio_mgmt_ctrl.sv
module test_mdio_mgmt_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;
  localparam logic [2:0] A_CFG = 3'd0, A_CMD = 3'd1, A_ADR = 3'd2,
                         A_WDAT = 3'd3, A_RDAT = 3'd4, A_IND = 3'd5;
  localparam int NVEC = 8;
  // {isRead, divCode, noPreamble, phy, reg, data}
  localparam logic [30:0] VEC [NVEC] = '{
    {1'b0, 3'd0, 1'b0, 5'h01, 5'h00, 16'h8000},
    {1'b0, 3'd3, 1'b1, 5'h1F, 5'h1F, 16'hA5C3},
    {1'b1, 3'd1, 1'b0, 5'h08, 5'h01, 16'h796D},
    {1'b1, 3'd5, 1'b1, 5'h10, 5'h11, 16'hFFFF},
    {1'b0, 3'd7, 1'b0, 5'h1E, 5'h04, 16'h0060},
    {1'b1, 3'd6, 1'b1, 5'h09, 5'h0A, 16'h0001},
    {1'b0, 3'd2, 1'b1, 5'h03, 5'h0B, 16'h1234},
    {1'b1, 3'd4, 1'b0, 5'h0C, 5'h1D, 16'hC0DE}
  };

  logic clk = 1'b0, rstN = 1'b0, regWrEn = 1'b0, mdioIn = 1'b0;
  logic [2:0] regAddr = 3'd0;
  logic [31:0] regWrData = 32'd0;
  logic [31:0] regRdData;
  logic mdc, mdioOut, mdioOe;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_mgmt_ctrl i_mdio_mgmt_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  int total = 0, bad = 0, cycles = 0;
  logic [63:0] capBits = '0, capOe = '0;
  int riseCnt = 0, halfMin = 999, halfMax = 0, togCnt = 0, preLen = 32;
  bit togSeen = 0;
  logic prevMdc = 1'b0;
  logic [15:0] phyData = '0;

  // pin monitor and PHY responder
  always @(negedge clk) begin
    int bp;
    cycles++;
    if (mdc !== prevMdc) begin
      if (togSeen) begin
        if (togCnt < halfMin) halfMin = togCnt;
        if (togCnt > halfMax) halfMax = togCnt;
      end
      togSeen = 1;
      togCnt = 1;
      if (mdc) begin
        capBits = {capBits[62:0], mdioOut};
        capOe   = {capOe[62:0], mdioOe};
        riseCnt++;
      end else begin
        bp = riseCnt - preLen;
        if (bp >= 16 && bp < 32) mdioIn = phyData[31-bp];
        else mdioIn = 1'b0;
      end
    end else togCnt++;
    prevMdc = mdc;
  end

  always @(negedge clk) begin
    if (cycles > WATCHDOG_CYCLES) begin
      total++; bad++;
      $display("FAIL R3 watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG_CYCLES);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic checkEq(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [2:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdData;
  endtask

  task automatic clearMon(input bit np, input logic [15:0] pd);
    capBits = '0; capOe = '0; riseCnt = 0;
    halfMin = 999; halfMax = 0; togSeen = 0;
    preLen = np ? 0 : 32;
    phyData = pd;
  endtask

  task automatic waitIdle(input string req);
    logic [31:0] v;
    int n;
    n = 0;
    do begin
      @(negedge clk);
      regRead(A_IND, v);
      n++;
    end while (v[0] && n < 5000);
    checkEq(req, "frame completes", 64'(v[0]), 64'd0);
  endtask

  function automatic int halfOf(input logic [2:0] code);
    case (code)
      3'd0, 3'd1: return 2;
      3'd2: return 3;
      3'd3: return 4;
      3'd4: return 5;
      3'd5: return 7;
      3'd6: return 10;
      default: return 14;
    endcase
  endfunction

  initial begin
    logic [31:0] v;
    int r;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    regRead(A_IND, v);  checkEq("R1", "indicators after reset", 64'(v), 64'd0);
    regRead(A_RDAT, v); checkEq("R1", "read data after reset", 64'(v), 64'd0);
    checkEq("R1", "mdc/oe after reset", {62'd0, mdc, mdioOe}, 64'd0);

    // R12 readback field placement
    regWrite(A_CFG, 32'h0000_00FF);
    regRead(A_CFG, v); checkEq("R12", "config readback", 64'(v), 64'h17);
    regWrite(A_ADR, 32'hFFFF_FFFF);
    regRead(A_ADR, v); checkEq("R12", "address readback", 64'(v), 64'h1F1F);

    // table of frames: R2 R3 R4 R5 R8 R9
    for (int i = 0; i < NVEC; i++) begin
      logic isRd, np;
      logic [2:0] dv;
      logic [4:0] ph, rg;
      logic [15:0] dt;
      logic [31:0] expBody;
      int expTot;
      {isRd, dv, np, ph, rg, dt} = VEC[i];
      expBody = {2'b01, (isRd ? 2'b10 : 2'b01), ph, rg, 2'b10, dt};
      expTot = np ? 32 : 64;
      regWrite(A_CFG, {27'd0, np, 1'b0, dv});
      regWrite(A_ADR, {19'd0, ph, 3'd0, rg});
      clearMon(np, dt);
      if (isRd) begin
        regWrite(A_CMD, 32'd0);
        regWrite(A_CMD, 32'd1);
        regRead(A_IND, v); checkEq("R5", "busy+not-valid at read start", 64'(v), 64'h5);
      end else begin
        regWrite(A_WDAT, {16'd0, dt});
        regRead(A_IND, v); checkEq("R3", "busy the cycle after launch", 64'(v), 64'h1);
      end
      waitIdle("R3");
      checkEq(np ? "R8" : "R3", "rising mdc count", 64'(riseCnt), 64'(expTot));
      checkEq("R9", "min half period", 64'(halfMin), 64'(halfOf(dv)));
      checkEq("R9", "max half period", 64'(halfMax), 64'(halfOf(dv)));
      if (!np) begin
        checkEq("R2", "preamble bits", capBits[63:32], 64'hFFFF_FFFF);
        checkEq("R2", "preamble driven", capOe[63:32], 64'hFFFF_FFFF);
      end
      if (isRd) begin
        checkEq("R4", "read header bits", 64'(capBits[31:18]), 64'(expBody[31:18]));
        checkEq("R4", "read drive pattern", 64'(capOe[31:0]), 64'hFFFC_0000);
        regRead(A_RDAT, v); checkEq("R4", "read data", 64'(v), 64'(dt));
        regRead(A_IND, v);  checkEq("R5", "not-valid cleared", 64'(v), 64'd0);
      end else begin
        checkEq("R2", "write frame bits", 64'(capBits[31:0]), 64'(expBody));
        checkEq("R2", "write drive pattern", 64'(capOe[31:0]), 64'hFFFF_FFFF);
      end
    end

    // R7 commands while busy are dropped
    regWrite(A_CFG, 32'd0);
    regWrite(A_ADR, 32'h0000_0102);
    clearMon(0, 16'h0);
    regWrite(A_WDAT, 32'h1357);
    repeat (20) @(negedge clk);
    regWrite(A_WDAT, 32'h2468);
    regWrite(A_CMD, 32'd0);
    regWrite(A_CMD, 32'd1);
    waitIdle("R7");
    checkEq("R7", "rises of first frame only", 64'(riseCnt), 64'd64);
    checkEq("R7", "body of first frame", 64'(capBits[31:0]),
            64'({2'b01, 2'b01, 5'h01, 5'h02, 2'b10, 16'h1357}));
    regRead(A_IND, v); checkEq("R7", "no read pending", 64'(v), 64'd0);
    repeat (200) @(negedge clk);
    checkEq("R7", "no later frame", 64'(riseCnt), 64'd64);
    regRead(A_WDAT, v); checkEq("R7", "stored write value kept", 64'(v), 64'h1357);

    // R6 read needs 0 then 1 (command bit already 1 here)
    clearMon(0, 16'h4B2D);
    regWrite(A_CMD, 32'd1);
    repeat (100) @(negedge clk);
    checkEq("R6", "repeated 1 starts nothing", 64'(riseCnt), 64'd0);
    regWrite(A_CMD, 32'd0);
    regWrite(A_CMD, 32'd1);
    regRead(A_IND, v); checkEq("R6", "re-armed read starts", 64'(v), 64'h5);
    waitIdle("R6");
    regRead(A_RDAT, v); checkEq("R6", "re-armed read data", 64'(v), 64'h4B2D);

    // R10 management reset aborts a read
    clearMon(0, 16'hFFFF);
    regWrite(A_CMD, 32'd0);
    regWrite(A_CMD, 32'd1);
    repeat (40) @(negedge clk);
    regWrite(A_CFG, 32'h8000_0003);
    regRead(A_IND, v); checkEq("R10", "indicators cleared by reset", 64'(v), 64'd0);
    @(negedge clk);
    checkEq("R10", "mdc/oe low after reset", {62'd0, mdc, mdioOe}, 64'd0);
    r = riseCnt;
    repeat (200) @(negedge clk);
    checkEq("R10", "frame stays aborted", 64'(riseCnt), 64'(r));
    regRead(A_CFG, v); checkEq("R10", "reset bit self clears", 64'(v), 64'h3);
    clearMon(0, 16'h0);
    regWrite(A_WDAT, 32'h0F0F);
    waitIdle("R10");
    checkEq("R10", "full frame after reset", 64'(riseCnt), 64'd64);

    // R11 scan request does nothing
    clearMon(0, 16'h0);
    regWrite(A_CMD, 32'd2);
    repeat (100) @(negedge clk);
    checkEq("R11", "scan starts no frame", 64'(riseCnt), 64'd0);
    regRead(A_IND, v); checkEq("R11", "scan indicator low", 64'(v), 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule